// File: doc/BRIEF.md
# Indexed Effective Address Generator

This unit forms operand addresses for a 16-bit processor whose instructions name an index register and an offset. A request carries an explicit mode code, a base select (X, Y, SP or PC), a 16-bit offset field, the two 8-bit accumulators A and B, the 16-bit accumulator D, and the current values of the four base registers. For most modes the address is formed from those inputs alone. One cycle later the unit reports the address together with a flag that says whether the base register must be written back, and the value to write.

The auto-modify modes step X, Y or SP by 1 to 8 before or after use. The step size is taken from the low three bits of the offset field plus one. The two indirect modes form a pointer and issue one word read on a simple request/acknowledge port. The fetched word becomes the final address. A request that arrives while that read is outstanding is ignored. A request that names PC in an auto-modify mode, or that uses an unassigned mode code, is flagged as illegal and changes nothing.

Top module: `idx_ea_gen`

## Requirements
- R1: Modes 0, 1 and 2 give base + offset, where the offset is `offset[4:0]` sign-extended (-16..+15), `offset[8:0]` sign-extended (-256..+255), or the full 16-bit field. Offset bits above the field are ignored, and any of the four bases may be used (base_sel 0=X, 1=Y, 2=SP, 3=PC).
- R2: Modes 3, 4 and 5 give base + A, base + B or base + D. A and B are zero-extended.
- R3: Pre-increment (mode 6) and pre-decrement (mode 7) step the base by `offset[2:0]+1`. The stepped value is both the address and the write-back value, with wb_en high and wb_sel equal to base_sel.
- R4: Post-increment (mode 8) and post-decrement (mode 9) use the unmodified base as the address and write back the stepped base.
- R5: An auto-modify mode with base_sel 3 (PC), or any mode code from 12 to 15, reports illegal=1, wb_en=0 and ea=0. wb_en is never high with wb_sel 3.
- R6: Mode 10 reads a pointer at base + 16-bit offset, and mode 11 reads it at base + D. rd_req stays high with a stable rd_addr until rd_ack arrives. The returned word, with rd_data[15:8] the byte at rd_addr and rd_data[7:0] the byte at rd_addr+1, becomes ea with ind_flag=1 and wb_en=0.
- R7: A non-indirect request accepted at a clock edge raises done for exactly the following cycle. An indirect result raises done in the cycle after the edge that samples rd_ack.
- R8: While a pointer read is outstanding, req_valid is ignored: no done is produced for it and rd_addr does not change.
- R9: All address sums and steps wrap modulo 2^16.
- R10: After reset, done, rd_req, wb_en and illegal are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| mode | input | 4 | Addressing mode code |
| base_sel | input | 2 | Base register: 0 X, 1 Y, 2 SP, 3 PC |
| offset | input | 16 | Offset field / step field |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| acc_d | input | 16 | Accumulator D |
| reg_x | input | 16 | Current X |
| reg_y | input | 16 | Current Y |
| reg_sp | input | 16 | Current SP |
| reg_pc | input | 16 | Current PC |
| rd_req | output | 1 | Pointer read request |
| rd_addr | output | 16 | Pointer address |
| rd_ack | input | 1 | Pointer read acknowledge |
| rd_data | input | 16 | Pointer word, high byte from rd_addr |
| done | output | 1 | Result valid for one cycle |
| ea | output | 16 | Effective address |
| ind_flag | output | 1 | Result came through a pointer |
| illegal | output | 1 | Request was rejected |
| wb_en | output | 1 | Base register must be written back |
| wb_sel | output | 2 | Base register to write |
| wb_value | output | 16 | Value to write back |

## Verification
A direct request driven at a falling edge is sampled at the next rising edge, and its result is checked just after that edge; the bench also checks that done has dropped one edge later. For indirect requests, the bench checks rd_req and rd_addr just after the accepting edge. Its memory model then acknowledges after a chosen number of falling edges, and the bench counts rising edges until done, expecting exactly the acknowledge delay plus one. The test for ignored requests holds req_valid high during an outstanding read. It then confirms that the next done carries the pointer result and that no second done follows.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;
  localparam int MODE_W = 4;
  localparam int SEL_W  = 2;

  localparam logic [MODE_W-1:0] MD_K5      = 4'd0;
  localparam logic [MODE_W-1:0] MD_K9      = 4'd1;
  localparam logic [MODE_W-1:0] MD_K16     = 4'd2;
  localparam logic [MODE_W-1:0] MD_ACCA    = 4'd3;
  localparam logic [MODE_W-1:0] MD_ACCB    = 4'd4;
  localparam logic [MODE_W-1:0] MD_ACCD    = 4'd5;
  localparam logic [MODE_W-1:0] MD_PREINC  = 4'd6;
  localparam logic [MODE_W-1:0] MD_PREDEC  = 4'd7;
  localparam logic [MODE_W-1:0] MD_POSTINC = 4'd8;
  localparam logic [MODE_W-1:0] MD_POSTDEC = 4'd9;
  localparam logic [MODE_W-1:0] MD_IND_K16 = 4'd10;
  localparam logic [MODE_W-1:0] MD_IND_D   = 4'd11;

  localparam logic [SEL_W-1:0] SEL_PC = 2'd3;

  function automatic logic mode_known(input logic [MODE_W-1:0] m);
    return m <= MD_IND_D;
  endfunction

  function automatic logic mode_auto(input logic [MODE_W-1:0] m);
    return (m >= MD_PREINC) && (m <= MD_POSTDEC);
  endfunction

  function automatic logic mode_pre(input logic [MODE_W-1:0] m);
    return (m == MD_PREINC) || (m == MD_PREDEC);
  endfunction

  function automatic logic mode_dec(input logic [MODE_W-1:0] m);
    return (m == MD_PREDEC) || (m == MD_POSTDEC);
  endfunction

  function automatic logic mode_ptr(input logic [MODE_W-1:0] m);
    return (m == MD_IND_K16) || (m == MD_IND_D);
  endfunction
endpackage

// File: rtl/idx_ea_base_mux.sv
module idx_ea_base_mux #(
  parameter int ADDR_W = 16,
  parameter int SEL_W  = 2
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [ADDR_W-1:0] r_x,
  input  logic [ADDR_W-1:0] r_y,
  input  logic [ADDR_W-1:0] r_sp,
  input  logic [ADDR_W-1:0] r_pc,
  output logic [ADDR_W-1:0] base
);
  localparam int NREG = 1 << SEL_W;
  logic [ADDR_W-1:0] bank [NREG];

  always_comb begin
    for (int i = 0; i < NREG; i++) bank[i] = '0;
    bank[0] = r_x;
    bank[1] = r_y;
    bank[2] = r_sp;
    bank[3] = r_pc;
  end

  assign base = bank[sel];
endmodule

// File: rtl/idx_ea_offset_sel.sv
module idx_ea_offset_sel
  import idx_ea_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int ACC_W   = 8,
  parameter int K_SHORT = 5,
  parameter int K_MID   = 9
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [ADDR_W-1:0] off_field,
  input  logic [ACC_W-1:0]  acc_a,
  input  logic [ACC_W-1:0]  acc_b,
  input  logic [ADDR_W-1:0] acc_d,
  output logic [ADDR_W-1:0] off_val
);
  localparam int PAD_W = ADDR_W - ACC_W;

  logic [ADDR_W-1:0] k_short;
  logic [ADDR_W-1:0] k_mid;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_ext
    if (i < K_SHORT) begin : g_s_low
      assign k_short[i] = off_field[i];
    end else begin : g_s_sign
      assign k_short[i] = off_field[K_SHORT-1];
    end
    if (i < K_MID) begin : g_m_low
      assign k_mid[i] = off_field[i];
    end else begin : g_m_sign
      assign k_mid[i] = off_field[K_MID-1];
    end
  end

  always_comb begin
    unique case (mode)
      MD_K5:               off_val = k_short;
      MD_K9:               off_val = k_mid;
      MD_K16, MD_IND_K16:  off_val = off_field;
      MD_ACCA:             off_val = {{PAD_W{1'b0}}, acc_a};
      MD_ACCB:             off_val = {{PAD_W{1'b0}}, acc_b};
      MD_ACCD, MD_IND_D:   off_val = acc_d;
      default:             off_val = '0;
    endcase
  end
endmodule

// File: rtl/idx_ea_calc.sv
module idx_ea_calc
  import idx_ea_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int STEP_W = 3
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] off_val,
  input  logic [STEP_W-1:0] step_field,
  output logic [ADDR_W-1:0] ea_direct,
  output logic [ADDR_W-1:0] ptr_addr,
  output logic [ADDR_W-1:0] mod_base
);
  localparam int PAD_W = ADDR_W - STEP_W;

  logic [ADDR_W-1:0] sum;
  logic [ADDR_W-1:0] step;

  assign sum  = base + off_val;
  assign step = {{PAD_W{1'b0}}, step_field} + {{(ADDR_W-1){1'b0}}, 1'b1};

  assign mod_base  = mode_dec(mode) ? (base - step) : (base + step);
  assign ptr_addr  = sum;

  always_comb begin
    if (mode_auto(mode)) ea_direct = mode_pre(mode) ? mod_base : base;
    else                 ea_direct = sum;
  end
endmodule

// File: rtl/idx_ea_ptr_seq.sv
module idx_ea_ptr_seq #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [ADDR_W-1:0] launch_addr,
  input  logic              rd_ack,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              idle,
  output logic              fetched
);
  typedef enum logic {ST_IDLE, ST_WAIT} seq_state_e;
  seq_state_e state;

  assign idle    = (state == ST_IDLE);
  assign rd_req  = (state == ST_WAIT);
  assign fetched = rd_req && rd_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      rd_addr <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (launch) begin
          state   <= ST_WAIT;
          rd_addr <= launch_addr;
        end
        ST_WAIT: if (rd_ack) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/idx_ea_gen.sv
module idx_ea_gen
  import idx_ea_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int ACC_W   = 8,
  parameter int K_SHORT = 5,
  parameter int K_MID   = 9,
  parameter int STEP_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [3:0]        mode,
  input  logic [1:0]        base_sel,
  input  logic [ADDR_W-1:0] offset,
  input  logic [ACC_W-1:0]  acc_a,
  input  logic [ACC_W-1:0]  acc_b,
  input  logic [ADDR_W-1:0] acc_d,
  input  logic [ADDR_W-1:0] reg_x,
  input  logic [ADDR_W-1:0] reg_y,
  input  logic [ADDR_W-1:0] reg_sp,
  input  logic [ADDR_W-1:0] reg_pc,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [ADDR_W-1:0] rd_data,
  output logic              done,
  output logic [ADDR_W-1:0] ea,
  output logic              ind_flag,
  output logic              illegal,
  output logic              wb_en,
  output logic [1:0]        wb_sel,
  output logic [ADDR_W-1:0] wb_value
);
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] off_val;
  logic [ADDR_W-1:0] ea_direct;
  logic [ADDR_W-1:0] ptr_addr;
  logic [ADDR_W-1:0] mod_base;
  logic              seq_idle;
  logic              fetched;

  // Named internal events, observed by the bound checker.
  logic accept;
  logic bad_req;
  logic launch_read;
  logic auto_ok;

  assign accept      = req_valid && seq_idle;
  assign bad_req     = !mode_known(mode) || (mode_auto(mode) && (base_sel == SEL_PC));
  assign launch_read = accept && !bad_req && mode_ptr(mode);
  assign auto_ok     = mode_auto(mode) && !bad_req;

  idx_ea_base_mux #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_base (
    .sel  (base_sel),
    .r_x  (reg_x),
    .r_y  (reg_y),
    .r_sp (reg_sp),
    .r_pc (reg_pc),
    .base (base)
  );

  idx_ea_offset_sel #(
    .ADDR_W(ADDR_W), .ACC_W(ACC_W), .K_SHORT(K_SHORT), .K_MID(K_MID)
  ) u_off (
    .mode      (mode),
    .off_field (offset),
    .acc_a     (acc_a),
    .acc_b     (acc_b),
    .acc_d     (acc_d),
    .off_val   (off_val)
  );

  idx_ea_calc #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_calc (
    .mode       (mode),
    .base       (base),
    .off_val    (off_val),
    .step_field (offset[STEP_W-1:0]),
    .ea_direct  (ea_direct),
    .ptr_addr   (ptr_addr),
    .mod_base   (mod_base)
  );

  idx_ea_ptr_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch      (launch_read),
    .launch_addr (ptr_addr),
    .rd_ack      (rd_ack),
    .rd_req      (rd_req),
    .rd_addr     (rd_addr),
    .idle        (seq_idle),
    .fetched     (fetched)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      ea       <= '0;
      ind_flag <= 1'b0;
      illegal  <= 1'b0;
      wb_en    <= 1'b0;
      wb_sel   <= '0;
      wb_value <= '0;
    end else begin
      done <= 1'b0;
      if (fetched) begin
        done     <= 1'b1;
        ea       <= rd_data;
        ind_flag <= 1'b1;
        illegal  <= 1'b0;
        wb_en    <= 1'b0;
        wb_value <= '0;
      end else if (accept && !launch_read) begin
        done     <= 1'b1;
        ea       <= bad_req ? '0 : ea_direct;
        ind_flag <= 1'b0;
        illegal  <= bad_req;
        wb_en    <= auto_ok;
        wb_sel   <= base_sel;
        wb_value <= auto_ok ? mod_base : '0;
      end
    end
  end
endmodule

// File: rtl/idx_ea_gen_chk.sv
module idx_ea_gen_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accept,
  input logic              launch_read,
  input logic              rd_req,
  input logic              rd_ack,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              done,
  input logic              ind_flag,
  input logic              illegal,
  input logic              wb_en,
  input logic [1:0]        wb_sel,
  input logic [ADDR_W-1:0] ea
);
  assert_illegal_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && illegal) |-> (!wb_en && (ea == '0)));

  assert_no_pc_writeback_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_sel != 2'd3));

  assert_read_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

  assert_ptr_no_writeback_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ind_flag) |-> !wb_en);

  assert_ptr_result_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_ack) |=> (done && ind_flag));

  assert_direct_result_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !launch_read) |=> (done && !ind_flag));

  assert_busy_no_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> !done);
endmodule

bind idx_ea_gen idx_ea_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .accept      (accept),
  .launch_read (launch_read),
  .rd_req      (rd_req),
  .rd_ack      (rd_ack),
  .rd_addr     (rd_addr),
  .done        (done),
  .ind_flag    (ind_flag),
  .illegal     (illegal),
  .wb_en       (wb_en),
  .wb_sel      (wb_sel),
  .ea          (ea)
);

// File: tb/idx_ea_gen_bench.sv
`timescale 1ns/1ps
module idx_ea_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  mode = '0;
  logic [1:0]  base_sel = '0;
  logic [15:0] offset = '0;
  logic [7:0]  acc_a = '0;
  logic [7:0]  acc_b = '0;
  logic [15:0] acc_d = '0;
  logic [15:0] reg_x = '0, reg_y = '0, reg_sp = '0, reg_pc = '0;
  logic        rd_req;
  logic [15:0] rd_addr;
  logic        rd_ack = 1'b0;
  logic [15:0] rd_data = '0;
  logic        done, ind_flag, illegal, wb_en;
  logic [15:0] ea, wb_value;
  logic [1:0]  wb_sel;

  int checks = 0;
  int errors = 0;
  int mem_lat = 0;
  int wait_cnt = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  idx_ea_gen u_idx_ea_gen (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
    .base_sel(base_sel), .offset(offset), .acc_a(acc_a), .acc_b(acc_b),
    .acc_d(acc_d), .reg_x(reg_x), .reg_y(reg_y), .reg_sp(reg_sp),
    .reg_pc(reg_pc), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
    .rd_data(rd_data), .done(done), .ea(ea), .ind_flag(ind_flag),
    .illegal(illegal), .wb_en(wb_en), .wb_sel(wb_sel), .wb_value(wb_value)
  );

  // Byte memory model: content is a fixed function of the address.
  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [15:0] be_word(input logic [15:0] a);
    logic [15:0] nxt;
    nxt = a + 16'd1;
    return {mem_byte(a), mem_byte(nxt)};
  endfunction

  function automatic logic [15:0] wrap(input logic [15:0] b, input int off);
    int t;
    t = (int'(b) + off) % 65536;
    if (t < 0) t += 65536;
    return t[15:0];
  endfunction

  function automatic int sx(input int v, input int n);
    return (v >= (1 << (n - 1))) ? v - (1 << n) : v;
  endfunction

  always @(negedge clk) begin
    if (rd_ack) rd_ack <= 1'b0;
    else if (rd_req) begin
      if (wait_cnt >= mem_lat) begin
        rd_ack   <= 1'b1;
        rd_data  <= be_word(rd_addr);
        wait_cnt <= 0;
      end else wait_cnt <= wait_cnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_direct(input logic [3:0] m, input logic [1:0] s, input logic [15:0] off,
                            input logic [15:0] exp_ea, input bit exp_ill, input bit exp_wb,
                            input logic [15:0] exp_wbv, input string tag);
    @(negedge clk);
    mode = m; base_sel = s; offset = off; req_valid = 1'b1;
    @(posedge clk); #1;
    chk({tag, " done"}, 16'(done), 16'd1);
    chk({tag, " ea"}, ea, exp_ea);
    chk({tag, " illegal"}, 16'(illegal), 16'(exp_ill));
    chk({tag, " ind"}, 16'(ind_flag), 16'd0);
    chk({tag, " wb_en"}, 16'(wb_en), 16'(exp_wb));
    if (exp_wb) begin
      chk({tag, " wb_sel"}, 16'(wb_sel), 16'(s));
      chk({tag, " wb_value"}, wb_value, exp_wbv);
    end
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk); #1;
    chk({tag, " done pulse"}, 16'(done), 16'd0);
  endtask

  task automatic run_ind(input logic [3:0] m, input logic [1:0] s, input logic [15:0] off,
                         input int lat, input logic [15:0] exp_ptr, input string tag);
    int n;
    @(negedge clk);
    mode = m; base_sel = s; offset = off; req_valid = 1'b1; mem_lat = lat;
    @(posedge clk); #1;
    chk({tag, " rd_req"}, 16'(rd_req), 16'd1);
    chk({tag, " rd_addr"}, rd_addr, exp_ptr);
    chk({tag, " early done"}, 16'(done), 16'd0);
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    do begin
      @(posedge clk); #1;
      n++;
    end while (!done && n < 50);
    chk({tag, " latency"}, 16'(n), 16'(lat + 1));
    chk({tag, " ea"}, ea, be_word(exp_ptr));
    chk({tag, " ind"}, 16'(ind_flag), 16'd1);
    chk({tag, " wb_en"}, 16'(wb_en), 16'd0);
    chk({tag, " illegal"}, 16'(illegal), 16'd0);
  endtask

  task automatic t_reset;
    chk("R10 done", 16'(done), 16'd0);
    chk("R10 rd_req", 16'(rd_req), 16'd0);
    chk("R10 wb_en", 16'(wb_en), 16'd0);
    chk("R10 illegal", 16'(illegal), 16'd0);
  endtask

  task automatic t_const;
    reg_x = 16'h1000; reg_y = 16'h2000; reg_sp = 16'hFFF0; reg_pc = 16'h8000;
    run_direct(4'd0, 2'd0, 16'h001F, wrap(16'h1000, sx(31, 5)), 0, 0, 0, "R1 k5 -1");
    run_direct(4'd0, 2'd0, 16'h0010, wrap(16'h1000, -16), 0, 0, 0, "R1 k5 -16");
    run_direct(4'd0, 2'd0, 16'hFFEF, wrap(16'h1000, 15), 0, 0, 0, "R1 k5 upper ignored");
    run_direct(4'd1, 2'd1, 16'h0100, wrap(16'h2000, -256), 0, 0, 0, "R1 k9 -256");
    run_direct(4'd1, 2'd1, 16'hFEFF, wrap(16'h2000, 255), 0, 0, 0, "R1 k9 +255");
    run_direct(4'd2, 2'd3, 16'h1234, 16'h9234, 0, 0, 0, "R1 k16 pc");
    run_direct(4'd2, 2'd2, 16'h0020, 16'h0010, 0, 0, 0, "R9 k16 wrap");
  endtask

  task automatic t_acc;
    acc_a = 8'hF0; acc_b = 8'h80; acc_d = 16'hFFFF;
    run_direct(4'd3, 2'd0, 16'h0000, 16'h10F0, 0, 0, 0, "R2 acc A zero-ext");
    run_direct(4'd4, 2'd1, 16'h0000, 16'h2080, 0, 0, 0, "R2 acc B zero-ext");
    reg_x = 16'h0001;
    run_direct(4'd5, 2'd0, 16'h0000, 16'h0000, 0, 0, 0, "R2 R9 acc D wrap");
    reg_x = 16'h1000;
  endtask

  task automatic t_auto;
    reg_x = 16'h3000;
    run_direct(4'd6, 2'd0, 16'h0007, 16'h3008, 0, 1, 16'h3008, "R3 pre-inc 8");
    run_direct(4'd7, 2'd1, 16'h0000, 16'h1FFF, 0, 1, 16'h1FFF, "R3 pre-dec 1");
    run_direct(4'd8, 2'd2, 16'h0002, 16'hFFF0, 0, 1, 16'hFFF3, "R4 post-inc 3");
    reg_x = 16'h0002;
    run_direct(4'd9, 2'd0, 16'h0004, 16'h0002, 0, 1, 16'hFFFD, "R4 R9 post-dec wrap");
    reg_x = 16'h1000;
  endtask

  task automatic t_illegal;
    run_direct(4'd6, 2'd3, 16'h0001, 16'h0000, 1, 0, 0, "R5 pc auto-modify");
    run_direct(4'd9, 2'd3, 16'h0001, 16'h0000, 1, 0, 0, "R5 pc post-dec");
    run_direct(4'd13, 2'd0, 16'h0001, 16'h0000, 1, 0, 0, "R5 unknown mode");
  endtask

  task automatic t_indirect;
    reg_x = 16'h4000; reg_pc = 16'hFF00; acc_d = 16'h00FF;
    run_ind(4'd10, 2'd0, 16'h0010, 0, 16'h4010, "R6 R7 ind k16 lat0");
    run_ind(4'd10, 2'd0, 16'h0011, 3, 16'h4011, "R6 R7 ind k16 lat3");
    run_ind(4'd11, 2'd3, 16'h0000, 1, 16'hFFFF, "R6 R9 ind D pc wrap");
  endtask

  task automatic t_busy;
    int n;
    reg_x = 16'h4000;
    @(negedge clk);
    mode = 4'd10; base_sel = 2'd0; offset = 16'h0020; req_valid = 1'b1; mem_lat = 4;
    @(posedge clk); #1;
    chk("R8 launch addr", rd_addr, 16'h4020);
    @(negedge clk);
    mode = 4'd2; offset = 16'h0005;
    @(posedge clk);
    @(posedge clk); #1;
    chk("R8 no done while busy", 16'(done), 16'd0);
    chk("R8 addr stable", rd_addr, 16'h4020);
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    do begin
      @(posedge clk); #1;
      n++;
    end while (!done && n < 50);
    chk("R8 first done is pointer", ea, be_word(16'h4020));
    chk("R8 first done ind", 16'(ind_flag), 16'd1);
    @(posedge clk); #1;
    chk("R8 no late result", 16'(done), 16'd0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_const();
    t_acc();
    t_auto();
    t_illegal();
    t_indirect();
    t_busy();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule